// File: doc/BRIEF.md
# Field-Rate Exposure Controller for a CCD Sensor

This block sets how long a CCD integrates charge in each field. It does this by emitting a substrate discharge pulse (`sub_pulse`) on the early lines of the field. Every pulse throws away the charge gathered so far. Only the lines after the last pulse count toward exposure, and they run up to charge readout at the end of the field. The exposure is held as a line count in `exp_lines`. A field with `F - exp_lines` discharge pulses leaves exactly `exp_lines` lines of integration.

A two-bit mode input chooses the source of the exposure:
- **Free iris:** an up/down loop driven by two digital flags from an external comparator, `too_bright` and `too_dark`.
- **Capped iris:** the same loop, with the exposure limited to the flicker-safe value.
- **Fixed shutter:** a speed chosen by a three-bit code.
- **Stopped:** no discharge pulses at all.

The mode and the speed code take effect only at the field strobe. `std_sel` chooses between the 525-line standard (0) and the 625-line standard (1). It sets the lines per field, the line rate used to convert shutter speeds to line counts, and the flicker cap.

Control is a five-state machine:
- **ST_WAIT:** after reset, until the first field strobe.
- **ST_IRIS**, **ST_LIMIT**, **ST_FIXED**, **ST_STOP:** one state per mode.

From any state, a field strobe moves to the state decoded from `mode_sel`. Without a field strobe, every state holds.

Top module: `expo_shutter_top`

## Requirements
- R1: `mode_sel` is sampled only on a cycle with `field_stb` high. The encoding is 00 free iris, 01 capped iris, 10 fixed shutter and 11 stopped. A change of `mode_sel` or `speed_code` in mid-field has no effect until the next field strobe.
- R2: In both iris modes, each field strobe updates the exposure by one step of 1 line:
  - `too_bright` alone lowers `exp_lines` by 1.
  - `too_dark` alone raises it by 1.
  - Neither flag, or both flags together, leaves it unchanged.
- R3: `exp_lines` changes only on a field strobe or during reset.
- R4: In iris modes, `exp_lines` saturates between 1 and the lines per field. The lines per field are 262 for `std_sel`=0 and 312 for `std_sel`=1.
- R5: In capped iris mode, `exp_lines` never exceeds the flicker cap of 157 lines (`std_sel`=0) or 130 lines (`std_sel`=1). Entering this mode clamps a larger value down to the cap.
- R6: In fixed mode, `exp_lines` loads `round(line_rate / D)`, with a minimum of 1. The line rate is 15734 Hz (`std_sel`=0) or 15625 Hz (`std_sel`=1). D depends on `speed_code` as follows:

  | `speed_code` | D | Lines, `std_sel`=0 | Lines, `std_sel`=1 |
  |---|---|---|---|
  | 7 | 100 (`std_sel`=0) or 120 (`std_sel`=1) | 157 | 130 |
  | 6 | 250 | 63 | 63 |
  | 5 | 500 | 31 | 31 |
  | 4 | 1000 | 16 | 16 |
  | 3 | 2000 | 8 | 8 |
  | 2 | 5000 | 3 | 3 |
  | 1 | 10000 | 2 | 2 |
  | 0 | 100000 | 1 | 1 |

- R7: In the iris and fixed modes, `sub_pulse` is high for exactly the cycle after a `line_stb`. This happens only for line indices 0 to `F-exp_lines-1`, counted from the field strobe. A field of F line strobes therefore carries `F-exp_lines` pulses.
- R8: In stopped mode, `sub_pulse` stays low and `exp_lines` holds its value.
- R9: While `rst_n` is low at a clock edge, `exp_lines` loads the lines per field of the current `std_sel`. After reset, `sub_pulse` stays low until the first field strobe.
- R10: `std_sel` picks the lines per field, the fixed-speed table and the flicker cap, all taken at the field strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle line strobe |
| field_stb | input | 1 | One-cycle field-start strobe |
| std_sel | input | 1 | 0: 525-line standard, 1: 625-line standard |
| mode_sel | input | 2 | 00 iris, 01 capped iris, 10 fixed, 11 stopped |
| speed_code | input | 3 | Fixed-shutter speed code |
| too_bright | input | 1 | Comparator flag: iris level above the speed-up threshold |
| too_dark | input | 1 | Comparator flag: iris level below the speed-down threshold |
| sub_pulse | output | 1 | Substrate discharge pulse, one cycle per selected line |
| exp_lines | output | 9 | Exposure in lines for the current field |

## Verification
The iris loop is stepped with bright-only, dark-only, no-flag and both-flag fields. This separates a step down from a step up and from a hold, and it drives the register into both of its saturation bounds. All eight speed codes are applied under both standards, so a wrong table entry or a swapped standard shows up in the pulse count per field. Flags, mode and speed code are also changed in mid-field, which catches logic that samples them outside the field strobe. A reset taken under the 625-line standard, followed by line strobes with no field strobe, distinguishes a correct reset load from pulses issued before the first field.

// File: rtl/expo_pkg.sv
package expo_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_IRIS,
        ST_LIMIT,
        ST_FIXED,
        ST_STOP
    } expo_state_t;

    // Mode pin pair to run state.
    function automatic expo_state_t mode_to_state(input logic [1:0] m);
        expo_state_t s;
        unique case (m)
            2'b00:   s = ST_IRIS;
            2'b01:   s = ST_LIMIT;
            2'b10:   s = ST_FIXED;
            default: s = ST_STOP;
        endcase
        return s;
    endfunction

    // Shutter divisor (1/D second) for a speed code.
    function automatic int unsigned speed_div(input int unsigned code,
                                              input int unsigned flick_div);
        int unsigned d;
        case (code)
            7:       d = flick_div;
            6:       d = 250;
            5:       d = 500;
            4:       d = 1000;
            3:       d = 2000;
            2:       d = 5000;
            1:       d = 10000;
            default: d = 100000;
        endcase
        return d;
    endfunction

    // Rounded line count for an exposure of 1/div second.
    function automatic int unsigned div_to_lines(input int unsigned line_hz,
                                                 input int unsigned div,
                                                 input int unsigned min_lines);
        int unsigned l;
        l = (line_hz + div / 2) / div;
        if (l < min_lines) l = min_lines;
        return l;
    endfunction

endpackage

// File: rtl/expo_mode_fsm.sv
module expo_mode_fsm
    import expo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        field_stb,
    input  logic [1:0]  mode_sel,
    output expo_state_t state_q,
    output expo_state_t state_d,
    output logic        sub_en
);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (field_stb) state_d = mode_to_state(mode_sel);
            ST_IRIS:  if (field_stb) state_d = mode_to_state(mode_sel);
            ST_LIMIT: if (field_stb) state_d = mode_to_state(mode_sel);
            ST_FIXED: if (field_stb) state_d = mode_to_state(mode_sel);
            ST_STOP:  if (field_stb) state_d = mode_to_state(mode_sel);
            default:  state_d = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_IRIS, ST_LIMIT, ST_FIXED: sub_en = 1'b1;
            default:                     sub_en = 1'b0;
        endcase
    end

    // R1: the run state moves only on a field strobe.
    p_state_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable(state_q))
        else $error("state changed without field strobe");

endmodule

// File: rtl/expo_level.sv
module expo_level
    import expo_pkg::*;
#(
    parameter int unsigned FIELD_EIA      = 262,
    parameter int unsigned FIELD_CCIR     = 312,
    parameter int unsigned LINE_HZ_EIA    = 15734,
    parameter int unsigned LINE_HZ_CCIR   = 15625,
    parameter int unsigned FLICK_DIV_EIA  = 100,
    parameter int unsigned FLICK_DIV_CCIR = 120,
    parameter int unsigned STEP           = 1,
    parameter int unsigned MIN_EXP        = 1,
    parameter int unsigned EXP_W          = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_stb,
    input  logic             std_sel,
    input  expo_state_t      state_q,
    input  expo_state_t      state_d,
    input  logic [2:0]       speed_code,
    input  logic             too_bright,
    input  logic             too_dark,
    output logic [EXP_W-1:0] exp_q
);

    localparam int unsigned FIELD_MAX = (FIELD_EIA > FIELD_CCIR) ? FIELD_EIA : FIELD_CCIR;
    localparam int unsigned N_STD     = 2;
    localparam int unsigned N_CODE    = 8;

    logic [EXP_W-1:0] fixed_tbl [N_STD][N_CODE];

    // Fixed-speed line counts, one table per standard.
    for (genvar s = 0; s < N_STD; s++) begin : g_std
        for (genvar c = 0; c < N_CODE; c++) begin : g_code
            assign fixed_tbl[s][c] = EXP_W'(div_to_lines(
                (s == 0) ? LINE_HZ_EIA : LINE_HZ_CCIR,
                speed_div(c, (s == 0) ? FLICK_DIV_EIA : FLICK_DIV_CCIR),
                MIN_EXP));
        end
    end

    logic [EXP_W-1:0] field_len;
    logic [EXP_W-1:0] flick_len;
    logic [EXP_W-1:0] cap;
    logic [EXP_W:0]   up_val;
    logic [EXP_W-1:0] stepped;
    logic [EXP_W-1:0] exp_d;

    assign field_len = std_sel ? EXP_W'(FIELD_CCIR) : EXP_W'(FIELD_EIA);
    assign flick_len = fixed_tbl[std_sel][N_CODE-1];
    assign up_val    = {1'b0, exp_q} + (EXP_W+1)'(STEP);

    always_comb begin
        cap     = (state_d == ST_LIMIT) ? flick_len : field_len;
        stepped = exp_q;
        if (too_bright && !too_dark) begin
            if (exp_q >= EXP_W'(MIN_EXP + STEP)) stepped = exp_q - EXP_W'(STEP);
            else                                 stepped = EXP_W'(MIN_EXP);
        end else if (too_dark && !too_bright) begin
            if (up_val <= {1'b0, cap}) stepped = up_val[EXP_W-1:0];
            else                       stepped = cap;
        end
        if (stepped > cap) stepped = cap;
    end

    always_comb begin
        exp_d = exp_q;
        if (field_stb) begin
            unique case (state_d)
                ST_IRIS, ST_LIMIT: exp_d = stepped;
                ST_FIXED:          exp_d = fixed_tbl[std_sel][speed_code];
                default:           exp_d = exp_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= field_len;
        else        exp_q <= exp_d;
    end

    p_exp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable(exp_q))
        else $error("exposure moved without field strobe");

    p_exp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q >= EXP_W'(MIN_EXP)) && (exp_q <= EXP_W'(FIELD_MAX)))
        else $error("exposure out of range");

    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIMIT) |-> (exp_q <= flick_len))
        else $error("capped iris above flicker limit");

endmodule

// File: rtl/expo_sub_gen.sv
module expo_sub_gen #(
    parameter int unsigned FIELD_EIA  = 262,
    parameter int unsigned FIELD_CCIR = 312,
    parameter int unsigned EXP_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             field_stb,
    input  logic             std_sel,
    input  logic             sub_en,
    input  logic [EXP_W-1:0] exp_q,
    output logic             sub_pulse
);

    localparam logic [EXP_W-1:0] CNT_TOP = '1;

    logic [EXP_W-1:0] line_cnt;
    logic [EXP_W-1:0] field_len;
    logic [EXP_W-1:0] limit;

    assign field_len = std_sel ? EXP_W'(FIELD_CCIR) : EXP_W'(FIELD_EIA);
    assign limit     = (exp_q >= field_len) ? '0 : field_len - exp_q;

    // Line index within the field, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                             line_cnt <= '0;
        else if (field_stb)                     line_cnt <= '0;
        else if (line_stb && line_cnt != CNT_TOP) line_cnt <= line_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sub_pulse <= 1'b0;
        else        sub_pulse <= line_stb && !field_stb && sub_en && (line_cnt < limit);
    end

    p_sub_after_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse |-> $past(line_stb))
        else $error("discharge pulse without line strobe");

    // Stopped and waiting states carry no pulse (R9 too).
    p_sub_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse |-> $past(sub_en))
        else $error("discharge pulse while disabled");

endmodule

// File: rtl/expo_shutter_top.sv
module expo_shutter_top
    import expo_pkg::*;
#(
    parameter int unsigned FIELD_EIA      = 262,
    parameter int unsigned FIELD_CCIR     = 312,
    parameter int unsigned LINE_HZ_EIA    = 15734,
    parameter int unsigned LINE_HZ_CCIR   = 15625,
    parameter int unsigned FLICK_DIV_EIA  = 100,
    parameter int unsigned FLICK_DIV_CCIR = 120,
    parameter int unsigned STEP           = 1,
    parameter int unsigned MIN_EXP        = 1,
    localparam int unsigned FIELD_MAX = (FIELD_EIA > FIELD_CCIR) ? FIELD_EIA : FIELD_CCIR,
    localparam int unsigned EXP_W     = $clog2(FIELD_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             field_stb,
    input  logic             std_sel,
    input  logic [1:0]       mode_sel,
    input  logic [2:0]       speed_code,
    input  logic             too_bright,
    input  logic             too_dark,
    output logic             sub_pulse,
    output logic [EXP_W-1:0] exp_lines
);

    expo_state_t state_q;
    expo_state_t state_d;
    logic        sub_en;

    expo_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_stb (field_stb),
        .mode_sel  (mode_sel),
        .state_q   (state_q),
        .state_d   (state_d),
        .sub_en    (sub_en)
    );

    expo_level #(
        .FIELD_EIA      (FIELD_EIA),
        .FIELD_CCIR     (FIELD_CCIR),
        .LINE_HZ_EIA    (LINE_HZ_EIA),
        .LINE_HZ_CCIR   (LINE_HZ_CCIR),
        .FLICK_DIV_EIA  (FLICK_DIV_EIA),
        .FLICK_DIV_CCIR (FLICK_DIV_CCIR),
        .STEP           (STEP),
        .MIN_EXP        (MIN_EXP),
        .EXP_W          (EXP_W)
    ) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_stb  (field_stb),
        .std_sel    (std_sel),
        .state_q    (state_q),
        .state_d    (state_d),
        .speed_code (speed_code),
        .too_bright (too_bright),
        .too_dark   (too_dark),
        .exp_q      (exp_lines)
    );

    expo_sub_gen #(
        .FIELD_EIA  (FIELD_EIA),
        .FIELD_CCIR (FIELD_CCIR),
        .EXP_W      (EXP_W)
    ) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_stb  (line_stb),
        .field_stb (field_stb),
        .std_sel   (std_sel),
        .sub_en    (sub_en),
        .exp_q     (exp_lines),
        .sub_pulse (sub_pulse)
    );

    // R8: a stopped field leaves the exposure untouched.
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_stb && mode_sel == 2'b11) |=> $stable(exp_lines))
        else $error("exposure moved on entering stop");

endmodule

// File: tb/sim_expo_shutter_top.sv
module sim_expo_shutter_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       field_stb = 1'b0;
    logic       std_sel = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [2:0] speed_code = 3'd0;
    logic       too_bright = 1'b0;
    logic       too_dark = 1'b0;
    logic       sub_pulse;
    logic [8:0] exp_lines;

    int checks = 0;
    int errors = 0;
    int sub_cnt = 0;
    logic cnt_clr = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    expo_shutter_top u0 (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
        .std_sel(std_sel), .mode_sel(mode_sel), .speed_code(speed_code),
        .too_bright(too_bright), .too_dark(too_dark),
        .sub_pulse(sub_pulse), .exp_lines(exp_lines)
    );

    always @(negedge clk) begin
        if (cnt_clr)        sub_cnt <= 0;
        else if (sub_pulse) sub_cnt <= sub_cnt + 1;
    end

    // {std, mode[1:0], code[2:0], bright, dark, exp[8:0], subs[8:0]}
    localparam int NV = 27;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'd0, 1'b1, 1'b0, 9'd261, 9'd1},
        {1'b0, 2'd0, 3'd0, 1'b1, 1'b0, 9'd260, 9'd2},
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 9'd260, 9'd2},
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 9'd261, 9'd1},
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 9'd262, 9'd0},
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 9'd262, 9'd0},
        {1'b0, 2'd0, 3'd0, 1'b1, 1'b1, 9'd262, 9'd0},
        {1'b0, 2'd1, 3'd0, 1'b0, 1'b0, 9'd157, 9'd105},
        {1'b0, 2'd1, 3'd0, 1'b0, 1'b1, 9'd157, 9'd105},
        {1'b0, 2'd1, 3'd0, 1'b1, 1'b0, 9'd156, 9'd106},
        {1'b0, 2'd2, 3'd7, 1'b0, 1'b0, 9'd157, 9'd105},
        {1'b0, 2'd2, 3'd6, 1'b0, 1'b0, 9'd63,  9'd199},
        {1'b0, 2'd2, 3'd5, 1'b0, 1'b0, 9'd31,  9'd231},
        {1'b0, 2'd2, 3'd4, 1'b0, 1'b0, 9'd16,  9'd246},
        {1'b0, 2'd2, 3'd3, 1'b0, 1'b0, 9'd8,   9'd254},
        {1'b0, 2'd2, 3'd2, 1'b0, 1'b0, 9'd3,   9'd259},
        {1'b0, 2'd2, 3'd1, 1'b0, 1'b0, 9'd2,   9'd260},
        {1'b0, 2'd2, 3'd0, 1'b0, 1'b0, 9'd1,   9'd261},
        {1'b0, 2'd0, 3'd0, 1'b1, 1'b0, 9'd1,   9'd261},
        {1'b0, 2'd3, 3'd0, 1'b0, 1'b1, 9'd1,   9'd0},
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 9'd2,   9'd260},
        {1'b1, 2'd2, 3'd7, 1'b0, 1'b0, 9'd130, 9'd182},
        {1'b1, 2'd2, 3'd6, 1'b0, 1'b0, 9'd63,  9'd249},
        {1'b1, 2'd2, 3'd0, 1'b0, 1'b0, 9'd1,   9'd311},
        {1'b1, 2'd2, 3'd3, 1'b0, 1'b0, 9'd8,   9'd304},
        {1'b1, 2'd1, 3'd0, 1'b0, 1'b1, 9'd9,   9'd303},
        {1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 9'd9,   9'd303}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Optional field strobe, then n1 lines, optional mid-field change, then n2 lines.
    task automatic run_field(input bit with_vd, input int n1, input int n2,
                             input bit chg, input logic [1:0] m2,
                             input logic [2:0] c2, input logic b2, input logic d2);
        cnt_clr = 1'b1;
        field_stb = with_vd;
        tick();
        field_stb = 1'b0;
        cnt_clr = 1'b0;
        for (int i = 0; i < n1 + n2; i++) begin
            if (chg && i == n1) begin
                mode_sel = m2; speed_code = c2; too_bright = b2; too_dark = d2;
            end
            line_stb = 1'b1;
            tick();
            line_stb = 1'b0;
            repeat (3) tick();
        end
        repeat (2) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R9: reset load under 525-line standard.
        check("R9 reset exp", int'(exp_lines), 262);
        check("R9 reset sub", int'(sub_pulse), 0);
        rst_n = 1'b1;
        tick();
        run_field(1'b0, 20, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
        check("R9 no pulse before first field", sub_cnt, 0);

        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            int f;
            string tag;
            e = VEC[v];
            std_sel = e[25]; mode_sel = e[24:23]; speed_code = e[22:20];
            too_bright = e[19]; too_dark = e[18];
            f = e[25] ? 312 : 262;
            case (e[24:23])
                2'd0: tag = "R2 R4";
                2'd1: tag = "R5";
                2'd2: tag = e[25] ? "R6 R10" : "R6";
                default: tag = "R8";
            endcase
            run_field(1'b1, f, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
            check($sformatf("%s exp vec%0d", tag, v), int'(exp_lines), int'(e[17:9]));
            check($sformatf("R7 %s subs vec%0d", tag, v), sub_cnt, int'(e[8:0]));
        end

        // R1: mid-field mode/code change ignored until next field.
        std_sel = 1'b1; mode_sel = 2'b10; speed_code = 3'd0; too_bright = 0; too_dark = 0;
        run_field(1'b1, 100, 212, 1'b1, 2'b11, 3'd7, 1'b0, 1'b0);
        check("R1 mid-field mode change subs", sub_cnt, 311);
        check("R1 mid-field code change exp", int'(exp_lines), 1);
        run_field(1'b1, 312, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
        check("R8 stop subs", sub_cnt, 0);
        check("R8 stop exp", int'(exp_lines), 1);

        // R3: mid-field flag change does not move exposure.
        mode_sel = 2'b00; speed_code = 3'd0;
        run_field(1'b1, 50, 262, 1'b1, 2'b00, 3'd0, 1'b0, 1'b1);
        check("R3 exp held mid-field", int'(exp_lines), 1);
        run_field(1'b1, 312, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
        check("R2 dark step", int'(exp_lines), 2);
        check("R7 subs after dark step", sub_cnt, 310);

        // R9: reset under 625-line standard.
        too_dark = 0;
        rst_n = 1'b0;
        repeat (3) tick();
        check("R9 reset exp ccir", int'(exp_lines), 312);
        rst_n = 1'b1;
        tick();
        run_field(1'b0, 30, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
        check("R9 no pulse after reset", sub_cnt, 0);
        run_field(1'b1, 312, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
        check("R4 full-field exp", int'(exp_lines), 312);
        check("R7 full-field subs", sub_cnt, 0);
        too_bright = 1'b1;
        run_field(1'b1, 312, 0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
        check("R2 bright step ccir", int'(exp_lines), 311);
        check("R10 subs ccir", sub_cnt, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule